// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in whole hertz, the bus clock, the register-interface clock and the peripheral timer clock that a clock tree would produce for a given set of select and divider settings. The tree starts from a fixed 24 MHz oscillator. A system PLL multiplies it by 20 or 22, and two fractional taps scale the PLL by 18/frac. A secondary path offers a 480 MHz USB PLL, the oscillator or a dead source. A chain of divide-by-(1+n) stages follows.

Software or a boot sequencer sets the field inputs and pulses `start`. The block captures the fields on that edge. It runs four integer divisions, one after another, on a single shared restoring divider. It then raises `done` for one cycle together with the new frequencies. The outputs keep their values until the next computation completes.

Top module: `clkcalc_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done` and `frac_err` are 0 and all three frequency outputs are 0.
- R2: A `start` seen while idle makes `busy` 1 from the next cycle. `done` is a single-cycle pulse that appears exactly 4*(NUM_W+2) = 264 clock edges after the start edge (NUM_W=64). `busy` stays 1 until that edge.
- R3: The fields are captured on the accepted start edge. A `start` while busy is ignored. Field changes after capture have no effect. The outputs change only on the `done` cycle.
- R4: When `root_alt`=0, the root clock comes from the PLL path. The PLL is 24,000,000 x 22 when `sys_pll_hi`=1 and x 20 when it is 0. `pll_path_sel` selects the source: 0 = PLL, 1 = floor(PLL*18/`tap2_frac`), 2 = floor(PLL*18/`tap0_frac`), 3 = floor(PLL*18/(2*`tap2_frac`)).
- R5: When `root_alt`=1, the root is floor(src/(1+`alt_div`)). `alt_path_sel` picks src: 0 = 480,000,000, 1 = 24,000,000, and 2 or 3 = 0.
- R6: `ahb_hz` = floor(root/(1+`ahb_div`)) and `ipg_hz` = floor(ahb/(1+`ipg_div`)). Each stage uses the full-precision value of the stage before it.
- R7: `per_hz` = floor(P/(1+`perclk_div`)), where P is the IPG value when `perclk_osc`=0 and 24,000,000 when it is 1.
- R8: If the PLL path uses a tap (code 1, 2 or 3) whose fraction field is 0, `frac_err` is 1 on completion and the root clock is 0. An unused zero fraction does not set the error.
- R9: Any frequency above 2^32-1 is reported as 0xFFFFFFFF. Stages further down still divide the unsaturated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| sys_pll_hi | input | 1 | PLL multiplier: 1 = x22, 0 = x20 |
| tap0_frac | input | 6 | Fraction field of tap 0 |
| tap2_frac | input | 6 | Fraction field of tap 2 |
| pll_path_sel | input | 2 | PLL-path source code |
| alt_path_sel | input | 2 | Secondary-path source code |
| root_alt | input | 1 | Root select: 0 = PLL path, 1 = secondary path |
| alt_div | input | 3 | Secondary-path divider field |
| ahb_div | input | 3 | Bus clock divider field |
| ipg_div | input | 2 | Register clock divider field |
| perclk_osc | input | 1 | Peripheral source: 0 = IPG clock, 1 = oscillator |
| perclk_div | input | 6 | Peripheral divider field |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the outputs update |
| frac_err | output | 1 | Zero fraction used on the selected path |
| ahb_hz | output | 32 | Bus clock frequency in Hz |
| ipg_hz | output | 32 | Register clock frequency in Hz |
| per_hz | output | 32 | Peripheral clock frequency in Hz |

## Verification
A wrong value captured or held in the stage registers shows up only on the next `done` pulse, 264 cycles after start. It appears as a wrong frequency on `ahb_hz` and on every output derived from it. So each vector checks all three outputs and the error flag together. A sequencing fault, such as a lost divider-valid strobe or a stage that is skipped, shows at once as a `done` that comes early, late or twice. The bench therefore counts the exact latency and watches for extra pulses in a long quiet window.

// File: rtl/clkcalc_pkg.sv
// Shared constants and types for the clock tree frequency calculator.
// Assumes a fixed 24 MHz reference; field widths follow the select/divider inputs.
package clkcalc_pkg;

    localparam longint unsigned OSC_HZ   = 64'd24000000;
    localparam int              PLL_LO   = 20;
    localparam int              PLL_HI   = 22;
    localparam int              USB_MUL  = 20;
    localparam int              TAP_MUL  = 18;

    localparam int FRAC_W = 6;
    localparam int SEL_W  = 2;
    localparam int ADIV_W = 3;
    localparam int HDIV_W = 3;
    localparam int IDIV_W = 2;
    localparam int PDIV_W = 6;

    typedef struct packed {
        logic              pll_hi;
        logic [FRAC_W-1:0] tap0;
        logic [FRAC_W-1:0] tap2;
        logic [SEL_W-1:0]  psel;
        logic [SEL_W-1:0]  asel;
        logic              root_alt;
        logic [ADIV_W-1:0] adiv;
        logic [HDIV_W-1:0] hdiv;
        logic [IDIV_W-1:0] idiv;
        logic              posc;
        logic [PDIV_W-1:0] pdiv;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC,
        ST_AHB,
        ST_IPG,
        ST_PER
    } stage_t;

endpackage

// File: rtl/clkcalc_src.sv
// Root-source operand builder: forms the numerator and divisor of the first
// division stage from the captured configuration. Purely combinational.
// Assumes the caller discards the quotient when bad is set.
module clkcalc_src
    import clkcalc_pkg::*;
#(
    parameter int NUM_W = 64,
    parameter int DEN_W = 32
) (
    input  cfg_t             cfg,
    output logic [NUM_W-1:0] num,
    output logic [DEN_W-1:0] den,
    output logic             bad
);

    localparam logic [NUM_W-1:0] OSC_V = NUM_W'(OSC_HZ);
    localparam logic [NUM_W-1:0] USB_V = OSC_V * NUM_W'(USB_MUL);

    logic [NUM_W-1:0] pll_v;
    logic [NUM_W-1:0] tap_num;

    // PLL frequency and the numerator shared by both fractional taps
    always_comb begin
        pll_v   = cfg.pll_hi ? OSC_V * NUM_W'(PLL_HI) : OSC_V * NUM_W'(PLL_LO);
        tap_num = pll_v * NUM_W'(TAP_MUL);
    end

    // Pick numerator/divisor per root path and flag a used zero fraction
    always_comb begin
        num = '0;
        den = DEN_W'(1);
        bad = 1'b0;
        if (cfg.root_alt) begin
            case (cfg.asel)
                2'd0:    num = USB_V;
                2'd1:    num = OSC_V;
                default: num = '0;
            endcase
            den = DEN_W'(cfg.adiv) + DEN_W'(1);
        end else begin
            case (cfg.psel)
                2'd0: begin
                    num = pll_v;
                    den = DEN_W'(1);
                end
                2'd1: begin
                    num = tap_num;
                    den = DEN_W'(cfg.tap2);
                end
                2'd2: begin
                    num = tap_num;
                    den = DEN_W'(cfg.tap0);
                end
                default: begin
                    num = tap_num;
                    den = DEN_W'({cfg.tap2, 1'b0});
                end
            endcase
            bad = (cfg.psel != 2'd0) && (den == '0);
        end
    end

endmodule

// File: rtl/clkcalc_div.sv
// Restoring unsigned divider, one quotient bit per cycle, fixed NUM_W-cycle
// latency. A go pulse loads operands; valid pulses once with the quotient.
// Assumes go is only raised while no division is in flight.
module clkcalc_div #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             valid,
    output logic [NUM_W-1:0] quo
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             valid_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        trial = {rem_q, quo_q[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
    end

    // Load on go, then shift one quotient bit per cycle until the count expires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (go) begin
                quo_q <= num;
                rem_q <= '0;
                den_q <= den;
                cnt_q <= CNT_W'(NUM_W);
            end else if (cnt_q != '0) begin
                rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign valid = valid_q;
    assign quo   = quo_q;

    // R2
    div_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (cnt_q == '0));

    // R2
    div_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R6
    div_rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && den_q != '0) |-> (rem_q < den_q));

endmodule

// File: rtl/clkcalc_top.sv
// Clock tree frequency calculator top. Captures the select/divider fields on
// start, then runs four division stages (root, bus, register, peripheral) on
// one shared divider and publishes saturated 32-bit results with a done pulse.
// Assumes synchronous active-low reset held for at least two cycles.
module clkcalc_top
    import clkcalc_pkg::*;
#(
    parameter int NUM_W = 64,
    parameter int DEN_W = 32,
    parameter int OUT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sys_pll_hi,
    input  logic [5:0]        tap0_frac,
    input  logic [5:0]        tap2_frac,
    input  logic [1:0]        pll_path_sel,
    input  logic [1:0]        alt_path_sel,
    input  logic              root_alt,
    input  logic [2:0]        alt_div,
    input  logic [2:0]        ahb_div,
    input  logic [1:0]        ipg_div,
    input  logic              perclk_osc,
    input  logic [5:0]        perclk_div,
    output logic              busy,
    output logic              done,
    output logic              frac_err,
    output logic [OUT_W-1:0]  ahb_hz,
    output logic [OUT_W-1:0]  ipg_hz,
    output logic [OUT_W-1:0]  per_hz
);

    localparam logic [NUM_W-1:0] OSC_V = NUM_W'(OSC_HZ);

    cfg_t             cfg_in;
    cfg_t             cfg_q;
    stage_t           stage_q;
    logic             go_q;
    logic             bad_q;
    logic [NUM_W-1:0] root_q;
    logic [NUM_W-1:0] ahb_q;
    logic [NUM_W-1:0] ipg_q;
    logic [NUM_W-1:0] src_num;
    logic [DEN_W-1:0] src_den;
    logic             src_bad;
    logic [NUM_W-1:0] op_num;
    logic [DEN_W-1:0] op_den;
    logic             div_valid;
    logic [NUM_W-1:0] div_quo;
    logic             done_q;
    logic             err_q;
    logic [OUT_W-1:0] ahb_o_q;
    logic [OUT_W-1:0] ipg_o_q;
    logic [OUT_W-1:0] per_o_q;

    // Clamp a full-precision frequency to the output width
    function automatic logic [OUT_W-1:0] clamp(input logic [NUM_W-1:0] v);
        if (|v[NUM_W-1:OUT_W]) begin
            return '1;
        end
        return v[OUT_W-1:0];
    endfunction

    // Gather the field inputs into one record for capture
    always_comb begin
        cfg_in.pll_hi   = sys_pll_hi;
        cfg_in.tap0     = tap0_frac;
        cfg_in.tap2     = tap2_frac;
        cfg_in.psel     = pll_path_sel;
        cfg_in.asel     = alt_path_sel;
        cfg_in.root_alt = root_alt;
        cfg_in.adiv     = alt_div;
        cfg_in.hdiv     = ahb_div;
        cfg_in.idiv     = ipg_div;
        cfg_in.posc     = perclk_osc;
        cfg_in.pdiv     = perclk_div;
    end

    clkcalc_src #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_src (
        .cfg (cfg_q),
        .num (src_num),
        .den (src_den),
        .bad (src_bad)
    );

    // Route the operands of the stage now running to the shared divider
    always_comb begin
        case (stage_q)
            ST_AHB: begin
                op_num = root_q;
                op_den = DEN_W'(cfg_q.hdiv) + DEN_W'(1);
            end
            ST_IPG: begin
                op_num = ahb_q;
                op_den = DEN_W'(cfg_q.idiv) + DEN_W'(1);
            end
            ST_PER: begin
                op_num = cfg_q.posc ? OSC_V : ipg_q;
                op_den = DEN_W'(cfg_q.pdiv) + DEN_W'(1);
            end
            default: begin
                op_num = src_num;
                op_den = src_den;
            end
        endcase
    end

    clkcalc_div #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go_q),
        .num   (op_num),
        .den   (op_den),
        .valid (div_valid),
        .quo   (div_quo)
    );

    // Stage sequencer: capture, launch each division, store, publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            stage_q <= ST_IDLE;
            go_q    <= 1'b0;
            bad_q   <= 1'b0;
            root_q  <= '0;
            ahb_q   <= '0;
            ipg_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            ahb_o_q <= '0;
            ipg_o_q <= '0;
            per_o_q <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (stage_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        stage_q <= ST_SRC;
                        go_q    <= 1'b1;
                    end
                end
                ST_SRC: begin
                    if (div_valid) begin
                        root_q  <= src_bad ? '0 : div_quo;
                        bad_q   <= src_bad;
                        stage_q <= ST_AHB;
                        go_q    <= 1'b1;
                    end
                end
                ST_AHB: begin
                    if (div_valid) begin
                        ahb_q   <= div_quo;
                        stage_q <= ST_IPG;
                        go_q    <= 1'b1;
                    end
                end
                ST_IPG: begin
                    if (div_valid) begin
                        ipg_q   <= div_quo;
                        stage_q <= ST_PER;
                        go_q    <= 1'b1;
                    end
                end
                ST_PER: begin
                    if (div_valid) begin
                        ahb_o_q <= clamp(ahb_q);
                        ipg_o_q <= clamp(ipg_q);
                        per_o_q <= clamp(div_quo);
                        err_q   <= bad_q;
                        done_q  <= 1'b1;
                        stage_q <= ST_IDLE;
                    end
                end
                default: stage_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (stage_q != ST_IDLE);
    assign done     = done_q;
    assign frac_err = err_q;
    assign ahb_hz   = ahb_o_q;
    assign ipg_hz   = ipg_o_q;
    assign per_hz   = per_o_q;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ahb_hz) && $stable(ipg_hz) && $stable(per_hz) && $stable(frac_err)));

    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frac_err) |-> (ahb_hz == '0 && ipg_hz == '0));

    // R6
    chain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ipg_hz <= ahb_hz));

endmodule

// File: tb/clkcalc_top_test.sv
`timescale 1ns/1ps
module clkcalc_top_test;

    localparam int LAT = 4 * (64 + 2);

    typedef struct packed {
        logic        hi;
        logic [5:0]  f0;
        logic [5:0]  f2;
        logic [1:0]  psel;
        logic [1:0]  asel;
        logic        root;
        logic [2:0]  adiv;
        logic [2:0]  hdiv;
        logic [1:0]  idiv;
        logic        posc;
        logic [5:0]  pdiv;
        logic        err;
        logic [31:0] ahb;
        logic [31:0] ipg;
        logic [31:0] per;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R4 R6 R7 R8: PLL x22 direct, unused zero fractions
        '{1'b1, 6'd0,  6'd0,  2'd0, 2'd0, 1'b0, 3'd0, 3'd3, 2'd1, 1'b0, 6'd0,  1'b0, 32'd132000000, 32'd66000000,  32'd66000000},
        // R4 R7: tap 2, peripheral from oscillator
        '{1'b1, 6'd0,  6'd24, 2'd1, 2'd0, 1'b0, 3'd0, 3'd1, 2'd1, 1'b1, 6'd2,  1'b0, 32'd198000000, 32'd99000000,  32'd8000000},
        // R4: PLL x20 through tap 0
        '{1'b0, 6'd27, 6'd0,  2'd2, 2'd0, 1'b0, 3'd0, 3'd0, 2'd3, 1'b0, 6'd4,  1'b0, 32'd320000000, 32'd80000000,  32'd16000000},
        // R4: tap 2 halved
        '{1'b1, 6'd0,  6'd16, 2'd3, 2'd0, 1'b0, 3'd0, 3'd2, 2'd2, 1'b0, 6'd10, 1'b0, 32'd99000000,  32'd33000000,  32'd3000000},
        // R5: secondary USB PLL divided by 3
        '{1'b1, 6'd0,  6'd0,  2'd0, 2'd0, 1'b1, 3'd2, 3'd1, 2'd0, 1'b0, 6'd7,  1'b0, 32'd80000000,  32'd80000000,  32'd10000000},
        // R5: secondary oscillator
        '{1'b1, 6'd0,  6'd0,  2'd0, 2'd1, 1'b1, 3'd0, 3'd0, 2'd1, 1'b0, 6'd0,  1'b0, 32'd24000000,  32'd12000000,  32'd12000000},
        // R5: secondary bypass gives 0
        '{1'b1, 6'd0,  6'd0,  2'd0, 2'd2, 1'b1, 3'd0, 3'd0, 2'd0, 1'b1, 6'd5,  1'b0, 32'd0,          32'd0,          32'd4000000},
        // R5: reserved secondary code gives 0
        '{1'b1, 6'd0,  6'd0,  2'd0, 2'd3, 1'b1, 3'd0, 3'd0, 2'd0, 1'b0, 6'd0,  1'b0, 32'd0,          32'd0,          32'd0},
        // R8: tap 0 used with zero fraction
        '{1'b1, 6'd0,  6'd20, 2'd2, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b1, 6'd1,  1'b1, 32'd0,          32'd0,          32'd12000000},
        // R9: bus clock saturates, register clock keeps full precision
        '{1'b1, 6'd0,  6'd1,  2'd1, 2'd0, 1'b0, 3'd0, 3'd0, 2'd3, 1'b0, 6'd63, 1'b0, 32'hFFFFFFFF,  32'd2376000000, 32'd37125000},
        // R6: largest bus divider
        '{1'b0, 6'd0,  6'd0,  2'd0, 2'd0, 1'b0, 3'd0, 3'd7, 2'd3, 1'b0, 6'd0,  1'b0, 32'd60000000,  32'd15000000,  32'd15000000},
        // R8 R5: zero fractions unused on secondary path
        '{1'b1, 6'd0,  6'd0,  2'd2, 2'd0, 1'b1, 3'd7, 3'd0, 2'd1, 1'b1, 6'd63, 1'b0, 32'd60000000,  32'd30000000,  32'd375000},
        // R8: halved tap 2 with zero fraction
        '{1'b1, 6'd5,  6'd0,  2'd3, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 6'd0,  1'b1, 32'd0,          32'd0,          32'd0},
        // R4 R6: flooring at every stage
        '{1'b1, 6'd35, 6'd0,  2'd2, 2'd0, 1'b0, 3'd0, 3'd2, 2'd2, 1'b0, 6'd6,  1'b0, 32'd90514285,  32'd30171428,  32'd4310204}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        sys_pll_hi;
    logic [5:0]  tap0_frac;
    logic [5:0]  tap2_frac;
    logic [1:0]  pll_path_sel;
    logic [1:0]  alt_path_sel;
    logic        root_alt;
    logic [2:0]  alt_div;
    logic [2:0]  ahb_div;
    logic [1:0]  ipg_div;
    logic        perclk_osc;
    logic [5:0]  perclk_div;
    logic        busy;
    logic        done;
    logic        frac_err;
    logic [31:0] ahb_hz;
    logic [31:0] ipg_hz;
    logic [31:0] per_hz;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clkcalc_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sys_pll_hi   (sys_pll_hi),
        .tap0_frac    (tap0_frac),
        .tap2_frac    (tap2_frac),
        .pll_path_sel (pll_path_sel),
        .alt_path_sel (alt_path_sel),
        .root_alt     (root_alt),
        .alt_div      (alt_div),
        .ahb_div      (ahb_div),
        .ipg_div      (ipg_div),
        .perclk_osc   (perclk_osc),
        .perclk_div   (perclk_div),
        .busy         (busy),
        .done         (done),
        .frac_err     (frac_err),
        .ahb_hz       (ahb_hz),
        .ipg_hz       (ipg_hz),
        .per_hz       (per_hz)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input vec_t v);
        sys_pll_hi   = v.hi;
        tap0_frac    = v.f0;
        tap2_frac    = v.f2;
        pll_path_sel = v.psel;
        alt_path_sel = v.asel;
        root_alt     = v.root;
        alt_div      = v.adiv;
        ahb_div      = v.hdiv;
        ipg_div      = v.idiv;
        perclk_osc   = v.posc;
        perclk_div   = v.pdiv;
    endtask

    // Pulse start with the given fields; return edges until done and busy drops
    task automatic launch(input vec_t v, input vec_t other, input bit poke,
                          output int lat, output int busy_gaps);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        tick();
        start = 1'b0;
        lat = 0;
        busy_gaps = 0;
        for (int i = 0; i < 1000; i++) begin
            if (poke && i == 20) begin
                @(negedge clk);
                drive(other);
                start = 1'b1;
                tick();
                start = 1'b0;
            end else begin
                tick();
            end
            lat++;
            if (done) break;
            if (!busy) busy_gaps++;
        end
    endtask

    task automatic check_vec(input string tag, input vec_t v);
        chk(tag, "ahb_hz", ahb_hz, v.ahb);
        chk(tag, "ipg_hz", ipg_hz, v.ipg);
        chk(tag, "per_hz", per_hz, v.per);
        chk(tag, "frac_err", {31'd0, frac_err}, {31'd0, v.err});
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        int gaps;
        int extra;
        rst_n = 1'b0;
        start = 1'b0;
        drive(VECS[0]);
        repeat (4) tick();
        // R1: values while reset is held
        chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
        chk("R1", "done in reset", {31'd0, done}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1: values after release
        chk("R1", "frac_err", {31'd0, frac_err}, 32'd0);
        chk("R1", "ahb_hz", ahb_hz, 32'd0);
        chk("R1", "ipg_hz", ipg_hz, 32'd0);
        chk("R1", "per_hz", per_hz, 32'd0);

        // Vector table walk: R2 latency plus R4..R9 values
        for (int k = 0; k < NV; k++) begin
            launch(VECS[k], VECS[k], 1'b0, lat, gaps);
            chk("R2", $sformatf("latency vec %0d", k), lat, LAT);
            chk("R2", $sformatf("busy gaps vec %0d", k), gaps, 0);
            check_vec($sformatf("R4-9 vec %0d", k), VECS[k]);
            tick();
            chk("R2", "done single pulse", {31'd0, done}, 32'd0);
            chk("R2", "busy after done", {31'd0, busy}, 32'd0);
        end

        // R3: start while busy is ignored and later field changes have no effect
        launch(VECS[3], VECS[9], 1'b1, lat, gaps);
        chk("R3", "latency with busy start", lat, LAT);
        check_vec("R3 busy start", VECS[3]);
        extra = 0;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (done) extra++;
        end
        chk("R3", "no second done", extra, 0);
        chk("R3", "busy stays low", {31'd0, busy}, 32'd0);
        check_vec("R3 hold", VECS[3]);

        // R3: new fields without start leave outputs alone
        @(negedge clk);
        drive(VECS[6]);
        repeat (20) tick();
        check_vec("R3 no start", VECS[3]);

        // R1: reset after a result clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) tick();
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1", "ahb after re-reset", ahb_hz, 32'd0);
        chk("R1", "per after re-reset", per_hz, 32'd0);

        // R8: error clears on the next clean computation
        launch(VECS[8], VECS[8], 1'b0, lat, gaps);
        check_vec("R8 err set", VECS[8]);
        launch(VECS[1], VECS[1], 1'b0, lat, gaps);
        check_vec("R8 err cleared", VECS[1]);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule